// File: doc/BRIEF.md
# Cache Line Debug Read Port

This block holds the tag and data arrays of a small data cache and gives a debug agent a way to read any line by position rather than by address. A debug read forms an effective address from an index operand and a base operand. The base counts as zero when the caller says its register field is zero. Bits of that address pick a line and a word within the line. The block returns the word and two formatted tag snapshots, high and low. The snapshots carry the line's 36-bit real address, its valid flag, the dirty state of each doubleword and four page attributes. No tag comparison takes place.

Two write ports exist so the arrays can be loaded and dirtied for test. A fill port writes a whole line and marks it clean. A store port writes one word and marks its doubleword dirty.

A two-state machine paces the read. `S_IDLE` moves to `S_DONE` when `rd_en` is high, and `S_DONE` stays in `S_DONE` while `rd_en` remains high. `S_DONE` returns to `S_IDLE` when `rd_en` is low. `rd_done` is high exactly in `S_DONE`.

Bit positions below use LSB-0 numbering, with bit 31 the most significant bit of a 32-bit word.

Top module: `cache_dbg_read`

## Requirements
- R1: The effective address is `index_op + base_op` modulo 2^32 when `base_zero` is 0, and `index_op` alone when `base_zero` is 1.
- R2: The line is the effective address bits [5+LINE_BITS-1:5], and the word is bits [4:2]. `rd_word` returns that word of that line.
- R3: `misaligned` is set when effective address bits [1:0] are nonzero, and is registered together with the other read results. In that case `rd_word` may hold any value.
- R4: `tag_hi[31:8]` equals real address bits [31:8], `tag_hi[7]` equals the valid flag, and `tag_hi[3:0]` equals real address bits [35:32].
- R5: `tag_lo[7]`, `tag_lo[6]`, `tag_lo[5]` and `tag_lo[4]` are the dirty flags of doublewords 0, 1, 2 and 3, where doubleword 0 holds words 0 and 1. `tag_lo[3]`, `tag_lo[2]`, `tag_lo[1]` and `tag_lo[0]` are attribute bits `fill_attr[0]`, `[1]`, `[2]` and `[3]`.
- R6: `tag_hi[6:4]` and `tag_lo[31:8]` always read 0.
- R7: The word, both tags and `misaligned` update together from one line on the clock edge after `rd_en` is sampled. `rd_done` is high in the following cycle, and the results hold while `rd_en` stays low.
- R8: A fill writes word w from `fill_data[32*w+31:32*w]`, together with the real address, the valid flag and the attributes, and clears all four dirty flags. A store in the same cycle is ignored.
- R9: A store writes `st_data` to word `st_word` of line `st_line` and sets dirty flag `st_word/2` of that line.
- R10: After reset every line reads valid 0 and dirty 0, and all outputs are 0.
- R11: A debug read in the same cycle as a fill or store returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Debug read strobe |
| base_zero | input | 1 | Base register field is zero; base taken as 0 |
| base_op | input | 32 | Base operand |
| index_op | input | 32 | Index operand |
| fill_en | input | 1 | Write a whole line |
| fill_line | input | LINE_BITS | Line written by a fill |
| fill_data | input | 256 | Eight words of line data |
| fill_ra | input | 36 | Real address of the line |
| fill_valid | input | 1 | Valid flag written by the fill |
| fill_attr | input | 4 | Page attribute bits |
| st_en | input | 1 | Store one word |
| st_line | input | LINE_BITS | Line written by a store |
| st_word | input | 3 | Word written by a store |
| st_data | input | 32 | Store data |
| rd_word | output | 32 | Selected data word |
| tag_hi | output | 32 | Tag snapshot, high |
| tag_lo | output | 32 | Tag snapshot, low |
| rd_done | output | 1 | Read results valid this cycle |
| misaligned | output | 1 | Read address had nonzero low bits |

## Verification
Random operands, with `base_zero` both set and cleared, show whether the base is summed or dropped. Reads are mostly forced aligned, with some left misaligned, which separates the word path from the misalignment flag. Random stores to every word position, followed by reads, show whether each word maps to the correct dirty bit. Random fill addresses and attribute values spread nonzero bits over every tag field, so a swapped or shifted field shows up. Directed cases cover a read of an unfilled line after reset, a fill and a store to the same line in one cycle, and a read in the same cycle as a store.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    localparam int WORD_W  = 32;
    localparam int WORDS   = 8;
    localparam int RA_W    = 36;
    localparam int ATTR_W  = 4;
    localparam int DW_CNT  = WORDS / 2;
    localparam int LINE_W  = WORD_W * WORDS;

    typedef struct packed {
        logic [RA_W-1:0]   ra;
        logic              valid;
        logic [DW_CNT-1:0] dirty;
        logic [ATTR_W-1:0] attr;
    } line_tag_t;
endpackage

// File: rtl/cdr_ea_decode.sv
module cdr_ea_decode #(
    parameter int LINE_BITS = 6
) (
    input  logic [31:0]          base_op,
    input  logic                 base_zero,
    input  logic [31:0]          index_op,
    output logic [LINE_BITS-1:0] line,
    output logic [2:0]           word,
    output logic                 misalign
);
    logic [31:0] ea;
    logic        unused_ea;

    assign ea        = index_op + (base_zero ? 32'd0 : base_op);
    assign line      = ea[5 +: LINE_BITS];
    assign word      = ea[4:2];
    assign misalign  = |ea[1:0];
    assign unused_ea = ^ea[31:5+LINE_BITS];
endmodule

// File: rtl/cdr_tag_pack.sv
module cdr_tag_pack
    import cdr_pkg::*;
(
    input  line_tag_t   tag,
    output logic [31:0] hi,
    output logic [31:0] lo
);
    always_comb begin
        hi = {tag.ra[31:8], tag.valid, 3'b000, tag.ra[35:32]};
        lo = '0;
        for (int d = 0; d < DW_CNT; d++) begin
            lo[7-d] = tag.dirty[d];
        end
        for (int a = 0; a < ATTR_W; a++) begin
            lo[3-a] = tag.attr[a];
        end
    end
endmodule

// File: rtl/cdr_array.sv
module cdr_array
    import cdr_pkg::*;
#(
    parameter int LINE_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic [LINE_BITS-1:0] fill_line,
    input  logic [LINE_W-1:0]    fill_data,
    input  logic [RA_W-1:0]      fill_ra,
    input  logic                 fill_valid,
    input  logic [ATTR_W-1:0]    fill_attr,
    input  logic                 st_en,
    input  logic [LINE_BITS-1:0] st_line,
    input  logic [2:0]           st_word,
    input  logic [WORD_W-1:0]    st_data,
    input  logic [LINE_BITS-1:0] rd_line,
    input  logic [2:0]           rd_sel,
    output logic [WORD_W-1:0]    rd_data,
    output line_tag_t            rd_tag
);
    localparam int LINES = 1 << LINE_BITS;

    logic [WORD_W-1:0] mem  [LINES][WORDS];
    line_tag_t         tags [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                tags[l] <= '0;
            end
        end else if (fill_en) begin
            tags[fill_line] <= '{ra: fill_ra, valid: fill_valid,
                                 dirty: '0, attr: fill_attr};
        end else if (st_en) begin
            tags[st_line].dirty[st_word[2:1]] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[fill_line][w] <= fill_data[WORD_W*w +: WORD_W];
            end
        end else if (st_en) begin
            mem[st_line][st_word] <= st_data;
        end
    end

    assign rd_data = mem[rd_line][rd_sel];
    assign rd_tag  = tags[rd_line];

    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (tags[$past(fill_line)].dirty == '0));  // R8
    AST_STORE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && !fill_en) |=> tags[$past(st_line)].dirty[$past(st_word[2:1])]);  // R9
endmodule

// File: rtl/cache_dbg_read.sv
module cache_dbg_read
    import cdr_pkg::*;
#(
    parameter int LINE_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 base_zero,
    input  logic [31:0]          base_op,
    input  logic [31:0]          index_op,
    input  logic                 fill_en,
    input  logic [LINE_BITS-1:0] fill_line,
    input  logic [255:0]         fill_data,
    input  logic [35:0]          fill_ra,
    input  logic                 fill_valid,
    input  logic [3:0]           fill_attr,
    input  logic                 st_en,
    input  logic [LINE_BITS-1:0] st_line,
    input  logic [2:0]           st_word,
    input  logic [31:0]          st_data,
    output logic [31:0]          rd_word,
    output logic [31:0]          tag_hi,
    output logic [31:0]          tag_lo,
    output logic                 rd_done,
    output logic                 misaligned
);
    typedef enum logic {S_IDLE, S_DONE} state_t;

    state_t               state_q, state_d;
    logic [LINE_BITS-1:0] sel_line;
    logic [2:0]           sel_word;
    logic                 sel_mis;
    logic [31:0]          arr_word;
    line_tag_t            arr_tag;
    logic [31:0]          pk_hi, pk_lo;

    cdr_ea_decode #(.LINE_BITS(LINE_BITS)) u_dec (
        .base_op(base_op), .base_zero(base_zero), .index_op(index_op),
        .line(sel_line), .word(sel_word), .misalign(sel_mis)
    );

    cdr_array #(.LINE_BITS(LINE_BITS)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_line(fill_line), .fill_data(fill_data),
        .fill_ra(fill_ra), .fill_valid(fill_valid), .fill_attr(fill_attr),
        .st_en(st_en), .st_line(st_line), .st_word(st_word), .st_data(st_data),
        .rd_line(sel_line), .rd_sel(sel_word),
        .rd_data(arr_word), .rd_tag(arr_tag)
    );

    cdr_tag_pack u_pack (.tag(arr_tag), .hi(pk_hi), .lo(pk_lo));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = rd_en ? S_DONE : S_IDLE;
            S_DONE:  state_d = rd_en ? S_DONE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word    <= '0;
            tag_hi     <= '0;
            tag_lo     <= '0;
            misaligned <= 1'b0;
        end else if (rd_en) begin
            rd_word    <= arr_word;
            tag_hi     <= pk_hi;
            tag_lo     <= pk_lo;
            misaligned <= sel_mis;
        end
    end

    assign rd_done = (state_q == S_DONE);

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_done);  // R7
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(tag_hi) && $stable(tag_lo) && $stable(rd_word)));  // R7
    AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (misaligned == $past(sel_mis)));  // R3
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (tag_hi[6:4] == 3'b0 && tag_lo[31:8] == 24'b0));  // R6
endmodule

// File: tb/cache_dbg_read_test.sv
module cache_dbg_read_test;
    localparam int LB    = 6;
    localparam int LINES = 1 << LB;

    logic          clk = 0, rst_n = 0;
    logic          rd_en = 0, base_zero = 0;
    logic [31:0]   base_op = 0, index_op = 0;
    logic          fill_en = 0, fill_valid = 0;
    logic [LB-1:0] fill_line = 0, st_line = 0;
    logic [255:0]  fill_data = 0;
    logic [35:0]   fill_ra = 0;
    logic [3:0]    fill_attr = 0;
    logic          st_en = 0;
    logic [2:0]    st_word = 0;
    logic [31:0]   st_data = 0;
    logic [31:0]   rd_word, tag_hi, tag_lo;
    logic          rd_done, misaligned;

    int vectors = 0, fails = 0;

    logic [31:0] m_data  [LINES][8];
    logic [35:0] m_ra    [LINES];
    logic        m_valid [LINES];
    logic [3:0]  m_dirty [LINES];
    logic [3:0]  m_attr  [LINES];

    logic [31:0] e_word = 0, e_hi = 0, e_lo = 0;
    logic        e_mis = 0;

    always #10 clk = ~clk;

    cache_dbg_read #(.LINE_BITS(LB)) uut (.*);

    function automatic logic [31:0] ea_of(logic [31:0] b, logic bz, logic [31:0] x);
        return bz ? x : x + b;
    endfunction

    function automatic logic [31:0] hi_of(int l);
        logic [31:0] h = '0;
        for (int k = 0; k < 24; k++) h[31-k] = m_ra[l][31-k];
        h[7] = m_valid[l];
        h[3:0] = m_ra[l][35:32];
        return h;
    endfunction

    function automatic logic [31:0] lo_of(int l);
        logic [31:0] v = '0;
        for (int d = 0; d < 4; d++) v[7-d] = m_dirty[l][d];
        for (int a = 0; a < 4; a++) v[3-a] = m_attr[l][a];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: inputs already driven at negedge
    task automatic step();
        logic        r = rd_en;
        logic [31:0] ea = ea_of(base_op, base_zero, index_op);
        int          l = int'(ea[5 +: LB]);
        if (r) begin
            e_word = m_data[l][ea[4:2]];
            e_hi   = hi_of(l);
            e_lo   = lo_of(l);
            e_mis  = |ea[1:0];
        end
        @(posedge clk);
        if (fill_en) begin
            for (int w = 0; w < 8; w++) m_data[fill_line][w] = fill_data[32*w +: 32];
            m_ra[fill_line] = fill_ra; m_valid[fill_line] = fill_valid;
            m_attr[fill_line] = fill_attr; m_dirty[fill_line] = 4'b0;
        end else if (st_en) begin
            m_data[st_line][st_word] = st_data;
            m_dirty[st_line][st_word[2:1]] = 1'b1;
        end
        #5;
        chk("R7 done", {31'b0, rd_done}, {31'b0, r});
        chk("R3 misaligned", {31'b0, misaligned}, {31'b0, e_mis});
        if (!e_mis) chk("R2 word", rd_word, e_word);
        chk("R4 tag_hi", tag_hi, e_hi);
        chk("R5 tag_lo", tag_lo, e_lo);
        chk("R6 reserved", {tag_hi[6:4], tag_lo[31:8]}, 27'b0);
        @(negedge clk);
        rd_en = 0; fill_en = 0; st_en = 0;
    endtask

    task automatic set_read(logic [31:0] ea, logic bz);
        base_zero = bz;
        base_op   = $urandom();
        index_op  = bz ? ea : ea - base_op;
        rd_en     = 1;
    endtask

    task automatic set_fill(int l);
        fill_en = 1; fill_line = LB'(l);
        for (int w = 0; w < 8; w++) fill_data[32*w +: 32] = $urandom();
        fill_ra = {$urandom(), $urandom()};
        fill_valid = $urandom(); fill_attr = $urandom();
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int l = 0; l < LINES; l++) begin
            m_valid[l] = 0; m_dirty[l] = 0; m_ra[l] = 0; m_attr[l] = 0;
            for (int w = 0; w < 8; w++) m_data[l][w] = 'x;
        end
        repeat (3) @(negedge clk);
        // R10: outputs zero in reset
        chk("R10 reset word", rd_word, 0);
        chk("R10 reset hi", tag_hi, 0);
        chk("R10 reset lo", tag_lo, 0);
        chk("R10 reset done", {31'b0, rd_done}, 0);
        rst_n = 1;
        @(negedge clk);
        // R10: unfilled line reads invalid and clean
        set_read(32'h0000_0420, 1'b0);
        step();
        chk("R10 unfilled valid", {31'b0, tag_hi[7]}, 0);
        // R1: base ignored when base_zero is 1
        set_fill(5); step();
        base_zero = 1; base_op = 32'hFFFF_FFE0; index_op = 32'd5 << 5 | 32'd12;
        rd_en = 1; step();
        chk("R1 base dropped", rd_word, m_data[5][3]);
        // R8: fill and store same line same cycle, store ignored
        set_fill(9); st_en = 1; st_line = 9; st_word = 2; st_data = 32'hDEAD_BEEF;
        step();
        set_read(32'd9 << 5 | 32'd8, 1'b0); step();
        chk("R8 store dropped", {28'b0, tag_lo[7:4]}, 0);
        // R9, R11: store to word 7 while reading same word
        st_en = 1; st_line = 9; st_word = 7; st_data = 32'h1234_5678;
        set_read(32'd9 << 5 | 32'd28, 1'b1); step();
        chk("R11 old data", rd_word, e_word);
        set_read(32'd9 << 5 | 32'd28, 1'b0); step();
        chk("R9 dirty dw3", {28'b0, tag_lo[7:4]}, 32'h1);
        chk("R9 store data", rd_word, 32'h1234_5678);
        // R3: misaligned read
        set_read(32'd9 << 5 | 32'd2, 1'b0); step();
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) set_fill($urandom_range(0, LINES - 1));
            if (op >= 2 && op < 6) begin
                st_en = 1; st_line = $urandom(); st_word = $urandom(); st_data = $urandom();
            end
            if (op >= 4) begin
                logic [31:0] ea = $urandom();
                if ($urandom_range(0, 4) != 0) ea[1:0] = 2'b00;
                set_read(ea, $urandom_range(0, 1) == 1);
            end
            step();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule